// File: doc/BRIEF.md
# Five-Field Packet Rule Matcher

This block classifies packets by their IPv4 header tuple. For each key it takes the protocol, the source and destination addresses, and the source and destination ports, all qualified by a valid strobe. It checks the key against a small table of rules that software loads, and it reports whether any rule matched and which one. Each rule sets a prefix on each address, with a length from 0 to 32. It either names one protocol or accepts any protocol. It also carries a typed condition on the destination port: any port, one exact port, either of two ports, or any port strictly above a threshold.

All rules are compared in parallel in the cycle the key arrives. The resulting match vector is registered. A priority stage then picks the lowest-numbered matching rule and registers the result. Rules are written one whole rule per write through a configuration port. A key presented in a given cycle is always judged against the table as it stood before any write in that same cycle. Software can therefore rewrite entries while traffic flows.

Top module: `pkt_rule_matcher`

## Requirements
- R1: After reset, out_valid and out_hit are 0, out_idx is 0, and every rule entry is invalid, so no key can hit until rules are written.
- R2: A key accepted with in_valid high in cycle N produces out_valid high for exactly one cycle, in cycle N+2. Keys on consecutive cycles give results on consecutive cycles, in order.
- R3: An address condition holds when the top L bits of the key address equal those of the rule address, where L is the rule's prefix length (0 matches every address). A length above 32 is treated as 32.
- R4: A rule with cfg_proto_any=1 accepts every protocol. Otherwise the key protocol must equal the rule's 8-bit protocol value (for example 6 or 17).
- R5: The destination port mode is encoded as 0 = any port, 1 = equal to port_a, 2 = equal to port_a or port_b, 3 = strictly greater than port_a.
- R6: The source port has no effect on the result.
- R7: When several rules match, out_idx is the lowest index among them.
- R8: A rule whose valid bit is 0 never matches. Writing an entry with cfg_valid=0 removes it.
- R9: When no valid rule matches, out_hit is 0 and out_idx is 0 while out_valid is 1.
- R10: A key is classified against the table contents from before any write made in the same cycle or later. A write in the cycle the key is presented does not change that key's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Key present this cycle |
| in_proto | input | 8 | Key protocol number |
| in_src_ip | input | 32 | Key source address |
| in_src_port | input | 16 | Key source port (not used by any rule) |
| in_dst_ip | input | 32 | Key destination address |
| in_dst_port | input | 16 | Key destination port |
| cfg_we | input | 1 | Write one rule entry |
| cfg_idx | input | IDX_W (4) | Entry to write |
| cfg_valid | input | 1 | Entry enabled |
| cfg_src_ip | input | 32 | Rule source address |
| cfg_src_len | input | 6 | Rule source prefix length |
| cfg_dst_ip | input | 32 | Rule destination address |
| cfg_dst_len | input | 6 | Rule destination prefix length |
| cfg_proto_any | input | 1 | Rule accepts any protocol |
| cfg_proto | input | 8 | Rule protocol value |
| cfg_port_mode | input | 2 | Destination port mode (see R5) |
| cfg_port_a | input | 16 | First port value or threshold |
| cfg_port_b | input | 16 | Second port value |
| out_valid | output | 1 | Result pulse |
| out_hit | output | 1 | Some valid rule matched |
| out_idx | output | IDX_W (4) | Winning rule index |

## Verification
The bench builds the block with its default of 16 rules and a 4-bit index. Index 15 is then a legal entry, and the priority encoder is exercised across the full width. The loaded table includes overlapping rules, a disabled catch-all, and a prefix length above 32. It also has exact, pair and threshold port rules whose boundary values sit directly on the threshold, on neighbouring ports, and just outside a /22 and a /24 range.

// File: rtl/pkt_rule_pkg.sv
package pkt_rule_pkg;
  localparam int ADDR_W  = 32;
  localparam int PORT_W  = 16;
  localparam int PROTO_W = 8;
  localparam int LEN_W   = 6;

  typedef enum logic [1:0] {
    PORT_ANY  = 2'd0,
    PORT_EQ   = 2'd1,
    PORT_PAIR = 2'd2,
    PORT_GT   = 2'd3
  } port_mode_e;

  typedef struct packed {
    logic               valid;
    logic [ADDR_W-1:0]  src_addr;
    logic [LEN_W-1:0]   src_len;
    logic [ADDR_W-1:0]  dst_addr;
    logic [LEN_W-1:0]   dst_len;
    logic               proto_any;
    logic [PROTO_W-1:0] proto;
    port_mode_e         pmode;
    logic [PORT_W-1:0]  port_a;
    logic [PORT_W-1:0]  port_b;
  } rule_t;

  // Mask keeping the top 'len' bits; lengths past the width saturate.
  function automatic logic [ADDR_W-1:0] prefix_mask(input logic [LEN_W-1:0] len);
    if (len >= LEN_W'(ADDR_W)) return '1;
    return ~({ADDR_W{1'b1}} >> len);
  endfunction

  function automatic logic prefix_hit(input logic [ADDR_W-1:0] addr,
                                      input logic [ADDR_W-1:0] base,
                                      input logic [LEN_W-1:0]  len);
    logic [ADDR_W-1:0] m;
    m = prefix_mask(len);
    return (addr & m) == (base & m);
  endfunction

  function automatic logic port_hit(input port_mode_e        mode,
                                    input logic [PORT_W-1:0] port,
                                    input logic [PORT_W-1:0] a,
                                    input logic [PORT_W-1:0] b);
    logic r;
    unique case (mode)
      PORT_ANY:  r = 1'b1;
      PORT_EQ:   r = (port == a);
      PORT_PAIR: r = (port == a) || (port == b);
      PORT_GT:   r = (port > a);
      default:   r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rule_store.sv
module rule_store
  import pkt_rule_pkg::*;
#(
  parameter int N_RULES = 16,
  parameter int IDX_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  rule_t                   wr_rule,
  output rule_t [N_RULES-1:0]     rules
);
  for (genvar g = 0; g < N_RULES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        rules[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        rules[g] <= wr_rule;
    end
  end
endmodule

// File: rtl/rule_match.sv
module rule_match
  import pkt_rule_pkg::*;
(
  input  rule_t               rule,
  input  logic [PROTO_W-1:0]  key_proto,
  input  logic [ADDR_W-1:0]   key_src,
  input  logic [ADDR_W-1:0]   key_dst,
  input  logic [PORT_W-1:0]   key_dport,
  output logic                hit
);
  logic src_ok, dst_ok, proto_ok, port_ok;

  always_comb begin
    src_ok   = prefix_hit(key_src, rule.src_addr, rule.src_len);
    dst_ok   = prefix_hit(key_dst, rule.dst_addr, rule.dst_len);
    proto_ok = rule.proto_any || (key_proto == rule.proto);
    port_ok  = port_hit(rule.pmode, key_dport, rule.port_a, rule.port_b);
    hit      = rule.valid && src_ok && dst_ok && proto_ok && port_ok;
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
    grant = any ? (N'(1) << idx) : '0;
  end
endmodule

// File: rtl/pkt_rule_matcher.sv
module pkt_rule_matcher
  import pkt_rule_pkg::*;
#(
  parameter int N_RULES = 16,
  localparam int IDX_W  = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [7:0]         in_proto,
  input  logic [31:0]        in_src_ip,
  input  logic [15:0]        in_src_port,
  input  logic [31:0]        in_dst_ip,
  input  logic [15:0]        in_dst_port,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_valid,
  input  logic [31:0]        cfg_src_ip,
  input  logic [5:0]         cfg_src_len,
  input  logic [31:0]        cfg_dst_ip,
  input  logic [5:0]         cfg_dst_len,
  input  logic               cfg_proto_any,
  input  logic [7:0]         cfg_proto,
  input  logic [1:0]         cfg_port_mode,
  input  logic [15:0]        cfg_port_a,
  input  logic [15:0]        cfg_port_b,
  output logic               out_valid,
  output logic               out_hit,
  output logic [IDX_W-1:0]   out_idx
);
  rule_t                 wr_rule;
  rule_t [N_RULES-1:0]   rules;
  logic  [N_RULES-1:0]   match_vec;
  logic  [N_RULES-1:0]   s1_vec;
  logic                  s1_valid;
  logic                  pick_any;
  logic  [IDX_W-1:0]     pick_idx;
  logic  [N_RULES-1:0]   pick_grant;
  logic                  unused_sport;

  assign unused_sport = ^in_src_port;

  always_comb begin
    wr_rule.valid     = cfg_valid;
    wr_rule.src_addr  = cfg_src_ip;
    wr_rule.src_len   = cfg_src_len;
    wr_rule.dst_addr  = cfg_dst_ip;
    wr_rule.dst_len   = cfg_dst_len;
    wr_rule.proto_any = cfg_proto_any;
    wr_rule.proto     = cfg_proto;
    wr_rule.pmode     = port_mode_e'(cfg_port_mode);
    wr_rule.port_a    = cfg_port_a;
    wr_rule.port_b    = cfg_port_b;
  end

  rule_store #(.N_RULES(N_RULES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_rule(wr_rule), .rules(rules)
  );

  for (genvar g = 0; g < N_RULES; g++) begin : g_cmp
    rule_match u_match (
      .rule(rules[g]), .key_proto(in_proto), .key_src(in_src_ip),
      .key_dst(in_dst_ip), .key_dport(in_dst_port), .hit(match_vec[g])
    );

    assert_disabled_rule_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rules[g].valid |-> !match_vec[g]);
  end

  // Stage 1: capture the parallel compare against the pre-write table.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_vec   <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_vec   <= in_valid ? match_vec : '0;
    end
  end

  prio_pick #(.N(N_RULES), .IDX_W(IDX_W)) u_pick (
    .req(s1_vec), .any(pick_any), .idx(pick_idx), .grant(pick_grant)
  );

  // Stage 2: registered result.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_idx   <= '0;
    end else begin
      out_valid <= s1_valid;
      out_hit   <= s1_valid && pick_any;
      out_idx   <= (s1_valid && pick_any) ? pick_idx : '0;
    end
  end

  assert_result_two_cycles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);
  assert_hit_only_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> out_valid);
  assert_miss_idx_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_idx == '0));
  assert_grant_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_grant) && ((pick_grant & ~s1_vec) == '0));
  assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pick_grant - N_RULES'(1)) & s1_vec) == '0);
  assert_hit_follows_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> (out_hit == $past(|s1_vec)));
endmodule

// File: tb/tb_pkt_rule_matcher.sv
module tb_pkt_rule_matcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_proto = '0;
  logic [31:0] in_src_ip = '0;
  logic [15:0] in_src_port = '0;
  logic [31:0] in_dst_ip = '0;
  logic [15:0] in_dst_port = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic        cfg_valid = 1'b0;
  logic [31:0] cfg_src_ip = '0;
  logic [5:0]  cfg_src_len = '0;
  logic [31:0] cfg_dst_ip = '0;
  logic [5:0]  cfg_dst_len = '0;
  logic        cfg_proto_any = 1'b0;
  logic [7:0]  cfg_proto = '0;
  logic [1:0]  cfg_port_mode = '0;
  logic [15:0] cfg_port_a = '0;
  logic [15:0] cfg_port_b = '0;
  logic        out_valid;
  logic        out_hit;
  logic [3:0]  out_idx;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pkt_rule_matcher dut (.*);

  typedef struct packed {
    logic [31:0] dst;
    logic [31:0] src;
    logic [7:0]  proto;
    logic [15:0] sport;
    logic [15:0] dport;
    logic        hit;
    logic [3:0]  idx;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{32'h0A010203, 32'h0A090007, 8'd6,  16'd5,     16'd9,    1'b1, 4'd0},  // R3 /32 pair
    '{32'h0A020345, 32'h0A090509, 8'd17, 16'd1000,  16'd80,   1'b1, 4'd1},  // R5 eq
    '{32'h0A020345, 32'h0A090509, 8'd17, 16'd65535, 16'd80,   1'b1, 4'd1},  // R6 sport
    '{32'h0A020345, 32'h0A090509, 8'd17, 16'd7,     16'd21,   1'b1, 4'd2},  // R5 pair b
    '{32'h0A020345, 32'h0A090509, 8'd17, 16'd7,     16'd20,   1'b1, 4'd2},  // R5 pair a
    '{32'h0A020345, 32'h0A090509, 8'd17, 16'd7,     16'd22,   1'b1, 4'd7},  // R5 pair miss
    '{32'h0A020345, 32'h0A090509, 8'd6,  16'd7,     16'd80,   1'b1, 4'd3},  // R4 tcp
    '{32'h0A020345, 32'h0A090509, 8'd1,  16'd7,     16'd80,   1'b1, 4'd7},  // R4 other
    '{32'h0A010804, 32'h0A09A3FF, 8'd6,  16'd7,     16'd1024, 1'b1, 4'd4},  // R5 gt
    '{32'h0A010804, 32'h0A09A3FF, 8'd6,  16'd7,     16'd1023, 1'b1, 4'd7},  // R5 gt edge
    '{32'h0A010804, 32'h0A09A400, 8'd6,  16'd7,     16'd2000, 1'b1, 4'd7},  // R3 /22 edge
    '{32'h0A071111, 32'h00000000, 8'd17, 16'd7,     16'd443,  1'b1, 4'd6},  // R7 overlap
    '{32'h0A071111, 32'h00000000, 8'd17, 16'd7,     16'd444,  1'b1, 4'd7},  // R7 fallback
    '{32'hC0A80001, 32'h0A090007, 8'd6,  16'd7,     16'd80,   1'b0, 4'd0},  // R9 R8 miss
    '{32'hC0000000, 32'h01020304, 8'd1,  16'd7,     16'd9,    1'b1, 4'd8},  // R3 len 40
    '{32'hC0000000, 32'h01020304, 8'd2,  16'd7,     16'd9,    1'b0, 4'd0},  // R4 mismatch
    '{32'hC0000000, 32'h01020305, 8'd1,  16'd7,     16'd9,    1'b0, 4'd0},  // R3 len 40 = 32
    '{32'h0A010202, 32'h0A090007, 8'd6,  16'd7,     16'd9,    1'b1, 4'd7},  // R3 /32 neighbour
    '{32'h0A020400, 32'h0A090509, 8'd17, 16'd7,     16'd80,   1'b1, 4'd7},  // R3 /24 edge
    '{32'h0A0000FF, 32'hFFFFFFFF, 8'd99, 16'd7,     16'd1,    1'b1, 4'd7}   // R3 /8 zero-len src
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put_rule(input int idx, input logic v, input logic [31:0] s, input logic [5:0] sl,
                          input logic [31:0] d, input logic [5:0] dl, input logic pany,
                          input logic [7:0] p, input logic [1:0] m, input logic [15:0] a,
                          input logic [15:0] b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_valid = v;
    cfg_src_ip = s; cfg_src_len = sl; cfg_dst_ip = d; cfg_dst_len = dl;
    cfg_proto_any = pany; cfg_proto = p; cfg_port_mode = m; cfg_port_a = a; cfg_port_b = b;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_key(input logic [31:0] d, input logic [31:0] s, input logic [7:0] p,
                         input logic [15:0] sp, input logic [15:0] dp);
    in_valid = 1'b1; in_dst_ip = d; in_src_ip = s; in_proto = p;
    in_src_port = sp; in_dst_port = dp;
  endtask

  task automatic run_key(input string req, input logic [31:0] d, input logic [31:0] s,
                         input logic [7:0] p, input logic [15:0] sp, input logic [15:0] dp,
                         input logic eh, input logic [3:0] ei);
    @(negedge clk);
    set_key(d, s, p, sp, dp);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(req, 32'(out_valid), 32'd1);
    chk(req, 32'(out_hit), 32'(eh));
    chk(req, 32'(out_idx), 32'(ei));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", 32'(out_valid), 32'd0);
    chk("R1", 32'(out_hit), 32'd0);
    chk("R1", 32'(out_idx), 32'd0);
    rst_n = 1'b1;
    // R1: empty table, catch-all style key misses
    run_key("R1", 32'h0A010203, 32'h0A090007, 8'd6, 16'd5, 16'd9, 1'b0, 4'd0);

    put_rule(0, 1, 32'h0A090007, 6'd32, 32'h0A010203, 6'd32, 1, 8'd0,  2'd0, 16'd0,    16'd0);
    put_rule(1, 1, 32'h0A090509, 6'd32, 32'h0A020300, 6'd24, 0, 8'd17, 2'd1, 16'd80,   16'd0);
    put_rule(2, 1, 32'h0A090509, 6'd32, 32'h0A020300, 6'd24, 0, 8'd17, 2'd2, 16'd20,   16'd21);
    put_rule(3, 1, 32'h0A090509, 6'd32, 32'h0A020300, 6'd24, 0, 8'd6,  2'd1, 16'd80,   16'd0);
    put_rule(4, 1, 32'h0A09A000, 6'd22, 32'h0A010804, 6'd32, 0, 8'd6,  2'd3, 16'd1023, 16'd0);
    put_rule(5, 0, 32'h00000000, 6'd0,  32'h00000000, 6'd0,  1, 8'd0,  2'd0, 16'd0,    16'd0);
    put_rule(6, 1, 32'h00000000, 6'd0,  32'h0A070000, 6'd16, 1, 8'd0,  2'd1, 16'd443,  16'd0);
    put_rule(7, 1, 32'h00000000, 6'd0,  32'h0A000000, 6'd8,  1, 8'd0,  2'd0, 16'd0,    16'd0);
    put_rule(8, 1, 32'h01020304, 6'd40, 32'h00000000, 6'd0,  0, 8'd1,  2'd0, 16'd0,    16'd0);

    for (int i = 0; i < NV; i++)
      run_key($sformatf("vector %0d (R3-R9 table)", i), VECS[i].dst, VECS[i].src, VECS[i].proto,
              VECS[i].sport, VECS[i].dport, VECS[i].hit, VECS[i].idx);

    // R15 index: highest entry usable, lowest still wins
    put_rule(15, 1, 32'h00000000, 6'd0, 32'hC0A80000, 6'd16, 1, 8'd0, 2'd0, 16'd0, 16'd0);
    run_key("R7", 32'hC0A80001, 32'h0A090007, 8'd6, 16'd7, 16'd80, 1'b1, 4'd15);

    // R8: disabling rule 0 lets rule 7 win
    put_rule(0, 0, 32'h0A090007, 6'd32, 32'h0A010203, 6'd32, 1, 8'd0, 2'd0, 16'd0, 16'd0);
    run_key("R8", 32'h0A010203, 32'h0A090007, 8'd6, 16'd5, 16'd9, 1'b1, 4'd7);

    // R10: write in the same cycle as the key does not affect it
    @(negedge clk);
    set_key(32'h0A550000, 32'h0, 8'd6, 16'd7, 16'd9);
    cfg_we = 1'b1; cfg_idx = 4'd7; cfg_valid = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    chk("R10", 32'(out_valid), 32'd1);
    chk("R10", 32'(out_hit), 32'd1);
    chk("R10", 32'(out_idx), 32'd7);
    run_key("R10", 32'h0A550000, 32'h0, 8'd6, 16'd7, 16'd9, 1'b0, 4'd0);

    // R2: back-to-back keys, ordered results, one-cycle pulses
    @(negedge clk);
    set_key(32'h0A020345, 32'h0A090509, 8'd17, 16'd1, 16'd80);
    @(negedge clk);
    set_key(32'h0A020345, 32'h0A090509, 8'd6, 16'd1, 16'd80);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", 32'(out_valid), 32'd1);
    chk("R2", 32'(out_idx), 32'd1);
    @(negedge clk);
    chk("R2", 32'(out_valid), 32'd1);
    chk("R2", 32'(out_idx), 32'd3);
    @(negedge clk);
    chk("R2", 32'(out_valid), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule